// File: doc/BRIEF.md
# Six-bit multi-cycle accumulator processor

This block is a small sequential processor with a 6-bit data path. It holds sixteen general registers, an accumulator, a program counter and an instruction register. It fetches 16-bit instruction words one at a time from a 32-word memory that holds both program and data. Each instruction takes one fetch cycle and one execute cycle. The instruction set covers negate, add, subtract, multiply, move, store and load. Add, subtract, multiply and move each come in an immediate form and a register form.

A host loads the memory through a test port while the core is idle or halted, then pulses the start input. The core runs from word 0 until it fetches an all-zero word, then raises its halted flag. Results are left in memory by store instructions. The host reads them back through the same test port, which can read at any time.

Top module: `nano6_core`

## Requirements
- R1: After reset the program counter, the accumulator and all sixteen registers are zero, `halted_o` is low and the core is idle, so test-port writes are accepted.
- R2: An instruction word holds the opcode in bits 15:12, field A in bits 11:6 and field B in bits 5:0. A register operand uses the low four bits of its field. Opcodes: 1 negate rA; 2 add imm; 3 add reg; 4 sub imm; 5 sub reg; 6 mul imm; 7 mul reg; 8 move imm; 9 move reg; 10 store; 11 load.
- R3: Each fetch loads the word at the program counter into the instruction register and advances the counter by one, modulo 32. A run of k non-zero instructions followed by a zero word raises `halted_o` exactly 2k+1 cycles after the clock edge that samples `start_i`.
- R4: Fetching a zero word ends the run without executing it. `halted_o` rises on the next cycle and stays high until a start pulse.
- R5: A start pulse while idle or halted clears `halted_o`, sets the program counter to 0 and begins fetching. Registers and the accumulator keep their values. A start pulse during a run has no effect.
- R6: Add forms rA + B modulo 64. B is field B itself (immediate form) or the value of rB (register form). The carry out of bit 5 is lost.
- R7: Subtract forms rA minus B modulo 64 by adding the inverted B plus one. In the register form B is the value held in rB. Negate replaces rA with 64 minus rA, modulo 64.
- R8: Multiply forms the 12-bit product of rA and B. The low six bits go to rA and the high six bits go to the accumulator.
- R9: In the move forms, a field value of exactly 0x10 names the accumulator. Field A equal to 0x10 makes the accumulator the destination. In the register form, field B equal to 0x10 makes the accumulator the source.
- R10: Store writes the value of rB, zero-extended to 16 bits, to the memory word at the low five bits of rA. Load puts bits 5:0 of the memory word at the low five bits of rB into rA.
- R11: Opcodes 0 and 12 to 15 in a non-zero word change no register, accumulator or memory word.
- R12: The test port reads the word at `tp_addr_i` combinationally at any time. A test write lands in memory only while the core is idle or halted and is ignored during a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, begins a run from word 0 |
| halted_o | output | 1 | High after a zero word is fetched |
| tp_we_i | input | 1 | Test-port write enable |
| tp_addr_i | input | 5 | Test-port word address |
| tp_wdata_i | input | 16 | Test-port write data |
| tp_rdata_o | output | 16 | Test-port read data of the addressed word |

## Verification
The assertions assume that every program reaching the core ends in a zero word. They also assume that `start_i` and `tp_we_i` are synchronous to the clock. Under these assumptions a run always returns to the halted state, and the start and halt properties are checked on every run. The stimulus keeps to these assumptions. Each random program body contains no stores, and a fixed epilogue follows it that stores the observed registers and ends in a zero word. As a result, no run can overwrite its own code or loop. Only one directed case pulses start and writes the test port during a run, which checks that both inputs are ignored there.

// File: rtl/nano6_pkg.sv
`timescale 1ns/1ps
package nano6_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_NEG  = 4'd1,
    OP_ADDI = 4'd2,
    OP_ADDR = 4'd3,
    OP_SUBI = 4'd4,
    OP_SUBR = 4'd5,
    OP_MULI = 4'd6,
    OP_MULR = 4'd7,
    OP_MOVI = 4'd8,
    OP_MOVR = 4'd9,
    OP_STR  = 4'd10,
    OP_LDM  = 4'd11
  } opc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_HALT
  } core_st_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_NEG,
    ALU_MUL
  } alu_fn_e;

endpackage

// File: rtl/nano6_alu.sv
`timescale 1ns/1ps
module nano6_alu import nano6_pkg::*; #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);

  localparam int PW = 2 * W;

  logic [W-1:0] add_x, add_y, sum;
  logic [W-1:0] carry;
  logic         add_cin;

  // one ripple chain serves add, subtract (a + ~b + 1) and negate (~a + 1)
  always_comb begin
    case (fn_i)
      ALU_SUB: begin add_x = a_i;  add_y = ~b_i; add_cin = 1'b1; end
      ALU_NEG: begin add_x = ~a_i; add_y = '0;   add_cin = 1'b1; end
      default: begin add_x = a_i;  add_y = b_i;  add_cin = 1'b0; end
    endcase
  end

  assign carry[0] = add_cin;

  for (genvar i = 0; i < W; i++) begin : g_rca
    assign sum[i] = add_x[i] ^ add_y[i] ^ carry[i];
    if (i < W - 1) begin : g_cy
      assign carry[i+1] = (add_x[i] & add_y[i]) | (carry[i] & (add_x[i] ^ add_y[i]));
    end
  end

  // shift-add array, one row per multiplier bit
  logic [PW-1:0] pacc [W+1];
  assign pacc[0] = '0;

  for (genvar j = 0; j < W; j++) begin : g_mul
    assign pacc[j+1] = pacc[j] + (b_i[j] ? (PW'(a_i) << j) : PW'(0));
  end

  always_comb begin
    if (fn_i == ALU_MUL) begin
      lo_o = pacc[W][W-1:0];
      hi_o = pacc[W][PW-1:W];
    end else begin
      lo_o = sum;
      hi_o = '0;
    end
  end

endmodule

// File: rtl/nano6_regfile.sv
`timescale 1ns/1ps
module nano6_regfile #(
  parameter int W  = 6,
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [IW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);

  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

endmodule

// File: rtl/nano6_mem.sv
`timescale 1ns/1ps
module nano6_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int LW    = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [LW-1:0] rdata_b_o,
  input  logic [AW-1:0] raddr_c_i,
  output logic [DW-1:0] rdata_c_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // a: fetch, b: load (data width only), c: test port
  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i][LW-1:0];
  assign rdata_c_o = mem_q[raddr_c_i];

endmodule

// File: rtl/nano6_core.sv
`timescale 1ns/1ps
module nano6_core import nano6_pkg::*; #(
  parameter int  DATA_W    = 6,
  parameter int  INSN_W    = 16,
  parameter int  OPC_W     = 4,
  parameter int  NUM_REGS  = 16,
  parameter int  MEM_WORDS = 32,
  localparam int FLD_W     = (INSN_W - OPC_W) / 2,
  localparam int REG_AW    = $clog2(NUM_REGS),
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              halted_o,
  input  logic              tp_we_i,
  input  logic [MEM_AW-1:0] tp_addr_i,
  input  logic [INSN_W-1:0] tp_wdata_i,
  output logic [INSN_W-1:0] tp_rdata_o
);

  localparam logic [FLD_W-1:0] ACC_SEL = FLD_W'(NUM_REGS);

  core_st_e            state_q;
  logic [MEM_AW-1:0]   pc_q;
  logic [INSN_W-1:0]   ir_q;
  logic [DATA_W-1:0]   acc_q;

  opc_e                opc;
  logic [FLD_W-1:0]    fld_a, fld_b;
  logic [DATA_W-1:0]   imm;
  logic [DATA_W-1:0]   ra, rb, mv_src;

  alu_fn_e             alu_fn;
  logic [DATA_W-1:0]   alu_b, alu_lo, alu_hi;

  logic                rf_we;
  logic [DATA_W-1:0]   rf_wdata;
  logic                acc_we;
  logic [DATA_W-1:0]   acc_wdata;

  logic                st_we, tp_ok, mem_we;
  logic [MEM_AW-1:0]   mem_waddr;
  logic [INSN_W-1:0]   mem_wdata, fetch_word;
  logic [DATA_W-1:0]   ld_data;

  // decode
  assign opc   = opc_e'(ir_q[INSN_W-1 -: OPC_W]);
  assign fld_a = ir_q[2*FLD_W-1 -: FLD_W];
  assign fld_b = ir_q[FLD_W-1:0];
  assign imm   = DATA_W'(fld_b);

  nano6_regfile #(
    .W  (DATA_W),
    .N  (NUM_REGS),
    .IW (REG_AW)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (fld_a[REG_AW-1:0]),
    .wdata_i   (rf_wdata),
    .raddr_a_i (fld_a[REG_AW-1:0]),
    .rdata_a_o (ra),
    .raddr_b_i (fld_b[REG_AW-1:0]),
    .rdata_b_o (rb)
  );

  nano6_alu #(
    .W (DATA_W)
  ) u_alu (
    .a_i  (ra),
    .b_i  (alu_b),
    .fn_i (alu_fn),
    .lo_o (alu_lo),
    .hi_o (alu_hi)
  );

  assign mv_src = (fld_b == ACC_SEL) ? acc_q : rb;

  // execute-cycle control
  always_comb begin
    alu_fn    = ALU_ADD;
    alu_b     = imm;
    rf_we     = 1'b0;
    rf_wdata  = alu_lo;
    acc_we    = 1'b0;
    acc_wdata = alu_hi;
    st_we     = 1'b0;
    if (state_q == ST_EXEC) begin
      case (opc)
        OP_NEG:  begin alu_fn = ALU_NEG; rf_we = 1'b1; end
        OP_ADDI: begin rf_we = 1'b1; end
        OP_ADDR: begin alu_b = rb; rf_we = 1'b1; end
        OP_SUBI: begin alu_fn = ALU_SUB; rf_we = 1'b1; end
        OP_SUBR: begin alu_fn = ALU_SUB; alu_b = rb; rf_we = 1'b1; end
        OP_MULI: begin alu_fn = ALU_MUL; rf_we = 1'b1; acc_we = 1'b1; end
        OP_MULR: begin alu_fn = ALU_MUL; alu_b = rb; rf_we = 1'b1; acc_we = 1'b1; end
        OP_MOVI: begin
          if (fld_a == ACC_SEL) begin acc_we = 1'b1; acc_wdata = imm; end
          else begin rf_we = 1'b1; rf_wdata = imm; end
        end
        OP_MOVR: begin
          if (fld_a == ACC_SEL) begin acc_we = 1'b1; acc_wdata = mv_src; end
          else begin rf_we = 1'b1; rf_wdata = mv_src; end
        end
        OP_STR:  st_we = 1'b1;
        OP_LDM:  begin rf_we = 1'b1; rf_wdata = ld_data; end
        default: ;
      endcase
    end
  end

  // memory write arbitration: test port only while not running
  assign tp_ok     = (state_q == ST_IDLE) || (state_q == ST_HALT);
  assign mem_we    = st_we | (tp_we_i & tp_ok);
  assign mem_waddr = st_we ? ra[MEM_AW-1:0] : tp_addr_i;
  assign mem_wdata = st_we ? INSN_W'(rb) : tp_wdata_i;

  nano6_mem #(
    .DW    (INSN_W),
    .DEPTH (MEM_WORDS),
    .LW    (DATA_W)
  ) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (pc_q),
    .rdata_a_o (fetch_word),
    .raddr_b_i (rb[MEM_AW-1:0]),
    .rdata_b_o (ld_data),
    .raddr_c_i (tp_addr_i),
    .rdata_c_o (tp_rdata_o)
  );

  // sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
    end else begin
      if (acc_we) acc_q <= acc_wdata;
      case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start_i) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
          end
        end
        ST_FETCH: begin
          ir_q    <= fetch_word;
          pc_q    <= pc_q + MEM_AW'(1);
          state_q <= (fetch_word == '0) ? ST_HALT : ST_EXEC;
        end
        ST_EXEC:  state_q <= ST_FETCH;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign halted_o = (state_q == ST_HALT);

endmodule

// File: rtl/nano6_core_chk.sv
`timescale 1ns/1ps
module nano6_core_chk import nano6_pkg::*; #(
  parameter int AW = 5,
  parameter int IW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          halted_o,
  input core_st_e      state_i,
  input logic [AW-1:0] pc_i,
  input logic [IW-1:0] fetch_word_i,
  input logic [IW-1:0] ir_i,
  input logic          mem_we_i
);

  // R4
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !start_i |=> halted_o);

  // R4
  zero_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) && (fetch_word_i == '0) |=> halted_o);

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |=> pc_i == AW'($past(pc_i) + 1'b1));

  // R5
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_IDLE) || halted_o) && start_i |=> (state_i == ST_FETCH) && (pc_i == '0));

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC) |=> (state_i == ST_FETCH));

  // R12
  tp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |-> !mem_we_i);

  // R2
  exec_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC) |-> (ir_i != '0));

endmodule

bind nano6_core nano6_core_chk #(
  .AW (MEM_AW),
  .IW (INSN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .halted_o     (halted_o),
  .state_i      (state_q),
  .pc_i         (pc_q),
  .fetch_word_i (fetch_word),
  .ir_i         (ir_q),
  .mem_we_i     (mem_we)
);

// File: tb/nano6_core_test.sv
`timescale 1ns/1ps
module nano6_core_test;

  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int WORDS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          halted;
  logic          tp_we = 1'b0;
  logic [AW-1:0] tp_addr = '0;
  logic [DW-1:0] tp_wdata = '0;
  logic [DW-1:0] tp_rdata;

  int total = 0;
  int bad   = 0;

  int m_mem [WORDS];
  int m_r   [16];
  int m_acc;
  int img   [WORDS];

  always #2 clk = ~clk;

  nano6_core uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .halted_o   (halted),
    .tp_we_i    (tp_we),
    .tp_addr_i  (tp_addr),
    .tp_wdata_i (tp_wdata),
    .tp_rdata_o (tp_rdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int a, input int b);
    return ((op & 15) << 12) | ((a & 63) << 6) | (b & 63);
  endfunction

  function automatic int wrap6(input int v);
    return ((v % 64) + 64) % 64;
  endfunction

  // instruction-level model built from the requirements
  task automatic model_step(input int w);
    int op = (w >> 12) & 15;
    int a  = (w >> 6) & 63;
    int b  = w & 63;
    int ia = a & 15;
    int ib = b & 15;
    int src;
    int p;
    case (op)
      1:  m_r[ia] = wrap6(-m_r[ia]);
      2:  m_r[ia] = wrap6(m_r[ia] + b);
      3:  m_r[ia] = wrap6(m_r[ia] + m_r[ib]);
      4:  m_r[ia] = wrap6(m_r[ia] - b);
      5:  m_r[ia] = wrap6(m_r[ia] - m_r[ib]);
      6, 7: begin
        p = m_r[ia] * ((op == 6) ? b : m_r[ib]);
        m_r[ia] = p % 64;
        m_acc   = p / 64;
      end
      8: begin
        if (a == 16) m_acc = b; else m_r[ia] = b;
      end
      9: begin
        src = (b == 16) ? m_acc : m_r[ib];
        if (a == 16) m_acc = src; else m_r[ia] = src;
      end
      10: m_mem[m_r[ia] % 32] = m_r[ib];
      11: m_r[ia] = m_mem[m_r[ib] % 32] % 64;
      default: ;
    endcase
  endtask

  task automatic model_run(output int steps);
    int pc = 0;
    steps = 0;
    for (int g = 0; g < 200; g++) begin
      int w = m_mem[pc];
      pc = (pc + 1) % WORDS;
      if (w == 0) break;
      steps++;
      model_step(w);
    end
  endtask

  task automatic tp_write(input int a, input int d);
    @(negedge clk);
    tp_we    = 1'b1;
    tp_addr  = AW'(a);
    tp_wdata = DW'(d);
    @(negedge clk);
    tp_we    = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    tp_addr = AW'(a);
    #1;
    v = int'(tp_rdata);
  endtask

  task automatic clear_img();
    for (int i = 0; i < WORDS; i++) img[i] = 0;
  endtask

  task automatic load_image();
    for (int i = 0; i < WORDS; i++) begin
      tp_write(i, img[i]);
      m_mem[i] = img[i];
    end
  endtask

  task automatic compare_all(input string req);
    int v;
    @(negedge clk);
    for (int a = 0; a < WORDS; a++) begin
      peek(a, v);
      chk(req, $sformatf("mem[%0d]", a), v, m_mem[a]);
    end
  endtask

  // start a run; disturb pulses start and a test write to word 31 mid-run
  task automatic run_prog(input string req, input bit disturb);
    int steps;
    int n;
    model_run(steps);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5", "halted low after start", int'(halted), 0);
    n = 0;
    while (!halted && n < 2000) begin
      if (disturb && n == 3) begin
        start    = 1'b1;
        tp_we    = 1'b1;
        tp_addr  = AW'(31);
        tp_wdata = 16'h5555;
      end
      @(negedge clk);
      start = 1'b0;
      tp_we = 1'b0;
      n++;
    end
    chk(req, "R3 cycles from start to halt", n, 2 * steps + 1);
  endtask

  task automatic epilogue_store(input int base, input int first);
    // r5 points at base; stores r0, r1, r3?, chosen by caller afterward
    img[first] = enc(8, 5, base);
  endtask

  initial begin
    int v;
    int ops;
    void'($urandom(32'd1789));
    for (int i = 0; i < 16; i++) m_r[i] = 0;
    m_acc = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "halted after reset", int'(halted), 0);

    // ---- R1: registers and accumulator read back as zero
    clear_img();
    img[0]  = enc(8, 5, 28);   // r5 = 28
    img[1]  = enc(10, 5, 0);   // [r5] = r0
    img[2]  = enc(2, 5, 1);
    img[3]  = enc(9, 6, 16);   // r6 = acc
    img[4]  = enc(10, 5, 6);
    img[5]  = enc(2, 5, 1);
    img[6]  = enc(10, 5, 7);
    img[28] = 16'h1234;
    img[29] = 16'h2345;
    img[30] = 16'h3456;
    load_image();
    compare_all("R12 idle preload");
    run_prog("R1", 1'b0);
    @(negedge clk);
    peek(28, v); chk("R1", "r0 at reset", v, 0);
    peek(29, v); chk("R1", "acc at reset", v, 0);
    peek(30, v); chk("R1", "r7 at reset", v, 0);
    compare_all("R1");

    // ---- R6 R7 R8 arithmetic corners
    clear_img();
    img[0]  = enc(8, 0, 63);
    img[1]  = enc(2, 0, 1);    // 63+1 -> 0
    img[2]  = enc(4, 0, 1);    // 0-1 -> 63
    img[3]  = enc(8, 1, 63);
    img[4]  = enc(7, 1, 0);    // 63*63 = 0xF81
    img[5]  = enc(9, 2, 16);   // r2 = acc
    img[6]  = enc(1, 3, 0);    // neg 0
    img[7]  = enc(1, 0, 0);    // neg 63
    img[8]  = enc(8, 4, 5);
    img[9]  = enc(5, 4, 2);    // 5 - 62
    img[10] = enc(8, 5, 24);
    img[11] = enc(10, 5, 0);
    img[12] = enc(2, 5, 1);
    img[13] = enc(10, 5, 1);
    img[14] = enc(2, 5, 1);
    img[15] = enc(10, 5, 2);
    img[16] = enc(2, 5, 1);
    img[17] = enc(10, 5, 3);
    img[18] = enc(2, 5, 1);
    img[19] = enc(10, 5, 4);
    load_image();
    run_prog("R6", 1'b0);
    @(negedge clk);
    peek(24, v); chk("R7", "neg of 63 after add wrap and sub", v, 1);
    peek(25, v); chk("R8", "product low bits", v, 1);
    peek(26, v); chk("R8", "product high bits via acc", v, 62);
    peek(27, v); chk("R7", "neg of zero", v, 0);
    peek(28, v); chk("R7", "register subtract 5-62", v, 7);
    compare_all("R6");

    // ---- R9 R10 R11 R2 moves, aliasing, load, idle opcodes
    clear_img();
    img[0]  = enc(8, 16, 45);  // acc = 45
    img[1]  = enc(9, 0, 16);   // r0 = acc
    img[2]  = enc(8, 33, 9);   // field 0x21 -> r1
    img[3]  = enc(12, 0, 5);
    img[4]  = enc(15, 0, 7);
    img[5]  = enc(0, 0, 1);
    img[6]  = enc(8, 2, 30);
    img[7]  = enc(11, 3, 2);   // r3 = mem[30][5:0]
    img[8]  = enc(9, 16, 1);   // acc = r1
    img[9]  = enc(9, 4, 16);   // r4 = acc
    img[10] = enc(8, 5, 24);
    img[11] = enc(10, 5, 0);
    img[12] = enc(2, 5, 1);
    img[13] = enc(10, 5, 1);
    img[14] = enc(2, 5, 1);
    img[15] = enc(10, 5, 3);
    img[16] = enc(2, 5, 1);
    img[17] = enc(10, 5, 4);
    img[24] = 16'hFFFF;
    img[30] = 16'hABCD;
    img[31] = 16'h0F0F;
    load_image();
    run_prog("R9", 1'b0);
    @(negedge clk);
    peek(24, v); chk("R9", "acc as move destination then source", v, 45);
    peek(25, v); chk("R2", "upper field bits ignored for register index", v, 9);
    peek(26, v); chk("R10", "load keeps low six bits", v, 13);
    peek(27, v); chk("R11", "register untouched by idle opcodes", v, 9);
    compare_all("R10");

    // ---- R5 R12 start and test write ignored during run
    load_image();
    run_prog("R5", 1'b1);
    @(negedge clk);
    peek(31, v); chk("R12", "test write during run ignored", v, 16'h0F0F);
    compare_all("R5");
    repeat (10) @(negedge clk);
    chk("R4", "halted held", int'(halted), 1);
    tp_write(31, 16'h5555);
    m_mem[31] = 16'h5555;
    @(negedge clk);
    peek(31, v); chk("R12", "test write while halted", v, 16'h5555);

    // ---- random programs: store-free body, fixed epilogue, zero terminator
    for (int t = 0; t < 40; t++) begin
      clear_img();
      for (int i = 0; i < 8; i++) begin
        int a;
        int b;
        ops = $urandom_range(0, 15);
        if (ops == 10) ops = 11;
        a = ($urandom_range(0, 3) << 4) | $urandom_range(0, 3);
        b = ($urandom_range(0, 7) == 0) ? 16 : $urandom_range(0, 63);
        img[i] = enc(ops, a, b);
      end
      img[8]  = enc(9, 14, 16);
      img[9]  = enc(8, 15, 24);
      img[10] = enc(10, 15, 0);
      img[11] = enc(2, 15, 1);
      img[12] = enc(10, 15, 1);
      img[13] = enc(2, 15, 1);
      img[14] = enc(10, 15, 2);
      img[15] = enc(2, 15, 1);
      img[16] = enc(10, 15, 3);
      img[17] = enc(2, 15, 1);
      img[18] = enc(10, 15, 14);
      for (int i = 20; i < WORDS; i++) img[i] = $urandom_range(1, 65535);
      load_image();
      run_prog("R2", 1'b0);
      compare_all("R2 R6 R7 R8 R9 R10 R11 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule